// File: doc/BRIEF.md
# Serial Temperature Sensor Emulator

This block stands in for a read-only serial temperature sensor so that a serial master can be exercised without the physical part. The master raises a chip-enable line and supplies a serial clock. The emulator answers with a 16-bit frame built from a 10-bit temperature word presented on a parallel input. The word is two's-complement in quarter-degree Celsius steps. The frame opens with a zero, carries the ten temperature bits most significant first, and pads the tail by repeating the last data bit. A new bit appears on each rising serial clock edge, so the master can sample it on the following falling edge.

Both serial inputs are asynchronous to the system clock. Each passes through a two-flop synchronizer, and all serial-clock and chip-enable edges are detected from the synchronized copies. The serial data output comes as a data bit plus an output enable. The pad driver at the chip edge turns these into a high-impedance line whenever the enable is low. A frame checker counts serial clock rises per chip-enable pulse and raises an error flag for any pulse that is not exactly 16 clocks long. The temperature input is a level value with no handshake. It is copied into the frame register only while chip enable is low, so it never stalls and has no back-pressure. The serial data input exists for pin compatibility and is never read.

Top module: `thermo_emu`

## Requirements
- R1: `sdo_oe` is 1 while the synchronized chip enable is high and 0 otherwise, so the pad is high-impedance between frames.
- R2: Once chip enable is high and before the first serial clock rise of the pulse, `sdo_data` is 0. The first serial clock rise leaves it at 0, so the master samples the zero as frame bit 1.
- R3: Each later rise advances the frame. Frame bits 2 to 11 are `temp_in[9]` down to `temp_in[0]`.
- R4: Frame bits 12 to 16 equal `temp_in[0]`, and any further rises in the same pulse keep presenting `temp_in[0]`.
- R5: `temp_in` is captured only while chip enable is low. A change during a pulse does not alter that pulse's frame.
- R6: `sdi_unused` has no effect on any output.
- R7: A pulse with 1 to 15 serial clock rises sets `err` when chip enable falls.
- R8: A pulse with 17 or more rises sets `err`, at the latest when chip enable falls.
- R9: A pulse with exactly 16 rises, or with none, leaves `err` at 0.
- R10: `err` clears when chip enable next rises, and otherwise holds its value while chip enable stays low.
- R11: An active-low asynchronous reset drives `sdo_oe` and `err` to 0.
- R12: A chip-enable change reaches `sdo_oe` on the second system clock edge after it is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_en | input | 1 | Chip enable from the master, active high, asynchronous |
| ser_clk | input | 1 | Serial clock from the master, asynchronous |
| sdi_unused | input | 1 | Serial data from the master, ignored |
| temp_in | input | 10 | Temperature, two's-complement, 0.25 degree units |
| sdo_data | output | 1 | Serial data bit toward the master |
| sdo_oe | output | 1 | Output enable for the serial data pad driver |
| err | output | 1 | Set after a pulse that is not 16 clocks long |

## Verification
A wrong shift-register state shows up as a wrong bit at the first falling serial clock edge after the fault. A sweep over half of all temperature codes therefore exposes a bad load, a bad shift direction or a bad fill value within one frame. A wrong frame-length count shows up on `err` no later than three system clocks after chip enable falls. A stuck flag shows up three clocks after the next chip-enable rise. The bench probes the boundary counts 0, 5, 15, 16, 17 and 20 so that an off-by-one in the counter changes a visible flag value.

// File: rtl/thermo_emu_pkg.sv
package thermo_emu_pkg;

  // value of the bit that opens every frame
  localparam logic LEAD_VALUE = 1'b0;

  // width able to hold counts from zero up to frame_len + 1 (saturation point)
  function automatic int unsigned frame_cnt_width(input int unsigned frame_len);
    int unsigned w;
    w = 1;
    while ((32'd1 << w) < (frame_len + 2)) w++;
    return w;
  endfunction

endpackage

// File: rtl/thermo_sync_edge.sv
// Multi-stage synchronizer with edge detection on the synchronized copy.
module thermo_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level,
  output logic rise,
  output logic fall
);
  localparam int PW = STAGES + 1;

  logic [PW-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '0;
    else        pipe <= {pipe[PW-2:0], din};
  end

  assign level = pipe[STAGES-1];
  assign rise  = pipe[STAGES-1] & ~pipe[STAGES];
  assign fall  = ~pipe[STAGES-1] & pipe[STAGES];
endmodule

// File: rtl/thermo_piso.sv
// Parallel-in serial-out frame register: lead bit plus data, shifting left,
// the lowest bit refilled with itself so the last data bit repeats.
module thermo_piso #(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              shift,
  input  logic [DATA_W-1:0] par,
  output logic              ser
);
  import thermo_emu_pkg::*;
  localparam int REG_W = DATA_W + 1;

  logic [REG_W-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sr <= '0;
    else if (load)   sr <= {LEAD_VALUE, par};
    else if (shift)  sr <= {sr[REG_W-2:0], sr[0]};
  end

  assign ser = sr[REG_W-1];
endmodule

// File: rtl/thermo_frame_chk.sv
// Counts serial clock rises inside one chip-enable pulse and flags bad lengths.
module thermo_frame_chk #(
  parameter int FRAME_LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_lvl,
  input  logic ce_rise,
  input  logic ce_fall,
  input  logic sclk_rise,
  output logic err
);
  import thermo_emu_pkg::*;
  localparam int CNT_W = frame_cnt_width(FRAME_LEN);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(FRAME_LEN + 1);
  localparam logic [CNT_W-1:0] GOOD  = CNT_W'(FRAME_LEN);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (ce_rise) begin
      cnt <= sclk_rise ? CNT_W'(1) : '0;
    end else if (ce_lvl && sclk_rise && cnt != LIMIT) begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  err <= 1'b0;
    else if (ce_rise)                            err <= 1'b0;
    else if (ce_lvl && cnt == LIMIT)             err <= 1'b1;
    else if (ce_fall && cnt != '0 && cnt != GOOD) err <= 1'b1;
  end
endmodule

// File: rtl/thermo_emu.sv
module thermo_emu #(
  parameter int TEMP_W      = 10,
  parameter int FRAME_LEN   = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chip_en,
  input  logic              ser_clk,
  input  logic              sdi_unused,
  input  logic [TEMP_W-1:0] temp_in,
  output logic              sdo_data,
  output logic              sdo_oe,
  output logic              err
);
  logic ce_lvl, ce_rise, ce_fall;
  logic sclk_lvl_unused, sclk_rise, sclk_fall_unused;
  logic lead_hold;

  thermo_sync_edge #(.STAGES(SYNC_STAGES)) u_ce_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (chip_en),
    .level (ce_lvl),
    .rise  (ce_rise),
    .fall  (ce_fall)
  );

  thermo_sync_edge #(.STAGES(SYNC_STAGES)) u_sclk_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (ser_clk),
    .level (sclk_lvl_unused),
    .rise  (sclk_rise),
    .fall  (sclk_fall_unused)
  );

  // the first rise of a pulse presents the lead bit instead of shifting
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  lead_hold <= 1'b1;
    else if (!ce_lvl)            lead_hold <= 1'b1;
    else if (sclk_rise)          lead_hold <= 1'b0;
  end

  thermo_piso #(.DATA_W(TEMP_W)) u_piso (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (!ce_lvl),
    .shift (ce_lvl && sclk_rise && !lead_hold),
    .par   (temp_in),
    .ser   (sdo_data)
  );

  thermo_frame_chk #(.FRAME_LEN(FRAME_LEN)) u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_lvl    (ce_lvl),
    .ce_rise   (ce_rise),
    .ce_fall   (ce_fall),
    .sclk_rise (sclk_rise),
    .err       (err)
  );

  assign sdo_oe = ce_lvl;
endmodule

// File: rtl/thermo_emu_chk.sv
module thermo_emu_chk (
  input logic clk,
  input logic rst_n,
  input logic chip_en,
  input logic sdo_data,
  input logic sdo_oe,
  input logic err,
  input logic ce_lvl,
  input logic ce_rise,
  input logic ce_fall,
  input logic sclk_rise,
  input logic lead_hold
);
  logic [1:0] cyc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  // R1 R12
  oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'd3 && !chip_en && !$past(chip_en) && !$past(chip_en, 2)) |-> !sdo_oe);

  // R2
  lead_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_oe && lead_hold) |-> !sdo_data);

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_oe && !sclk_rise) |=> (!sdo_oe || $stable(sdo_data)));

  // R10
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ce_rise |=> !err);

  // R10
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_lvl && !ce_rise && !ce_fall) |=> $stable(err));
endmodule

bind thermo_emu thermo_emu_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .chip_en   (chip_en),
  .sdo_data  (sdo_data),
  .sdo_oe    (sdo_oe),
  .err       (err),
  .ce_lvl    (ce_lvl),
  .ce_rise   (ce_rise),
  .ce_fall   (ce_fall),
  .sclk_rise (sclk_rise),
  .lead_hold (lead_hold)
);

// File: tb/sim_thermo_emu.sv
`timescale 1ns/100ps
module sim_thermo_emu;
  localparam int HP = 5;   // system clocks per serial clock half period

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       chip_en = 1'b0;
  logic       ser_clk = 1'b0;
  logic       sdi_unused = 1'b0;
  logic [9:0] temp_in = '0;
  logic       sdo_data, sdo_oe, err;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  thermo_emu u0 (
    .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .ser_clk(ser_clk),
    .sdi_unused(sdi_unused), .temp_in(temp_in),
    .sdo_data(sdo_data), .sdo_oe(sdo_oe), .err(err)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic exp_bit(input logic [9:0] v, input int i);
    if (i == 0)       return 1'b0;
    else if (i <= 10) return v[10-i];
    else              return v[0];
  endfunction

  // sdi_mode: 0 toggling, 1 held high
  task automatic run_frame(input logic [9:0] v, input int nclk, input bit chg,
                           input int sdi_mode, output logic [15:0] got);
    got = '0;
    temp_in = v;
    tick(HP);
    chip_en = 1'b1;
    tick(HP);
    check(sdo_oe == 1'b1, "R1 oe in frame", sdo_oe, 1);
    check(err == 1'b0, "R10 err cleared on enable rise", err, 0);
    for (int i = 0; i < nclk; i++) begin
      ser_clk = 1'b1;
      sdi_unused = (sdi_mode == 1) ? 1'b1 : logic'(i % 2);
      tick(HP);
      if (chg && i == 0) temp_in = ~v;
      if (i < 16) got[15-i] = sdo_data;
      else check(sdo_data == v[0], "R4 repeat past 16", sdo_data, v[0]);
      ser_clk = 1'b0;
      tick(HP);
    end
    chip_en = 1'b0;
    tick(HP);
    check(sdo_oe == 1'b0, "R1 oe after frame", sdo_oe, 0);
  endtask

  function automatic logic [15:0] exp_word(input logic [9:0] v);
    logic [15:0] w;
    for (int i = 0; i < 16; i++) w[15-i] = exp_bit(v, i);
    return w;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] got;
    logic [9:0]  v;
    tick(3);
    // R11 reset state
    check(sdo_oe == 1'b0, "R11 oe in reset", sdo_oe, 0);
    check(err == 1'b0, "R11 err in reset", err, 0);
    rst_n = 1'b1;
    tick(4);

    // R12 latency of chip enable to oe
    chip_en = 1'b1;
    tick(1);
    check(sdo_oe == 1'b0, "R12 oe after one edge", sdo_oe, 0);
    tick(1);
    check(sdo_oe == 1'b1, "R12 oe after two edges", sdo_oe, 1);
    chip_en = 1'b0;
    tick(HP);

    // R2 R3 R4 sweep over half the codes, both parities
    for (int k = 0; k < 512; k++) begin
      v = 10'(k * 2 + (k % 2));
      run_frame(v, 16, 1'b0, 0, got);
      check(got == exp_word(v), "R2 R3 R4 frame word", got, exp_word(v));
      check(err == 1'b0, "R9 err after 16 clocks", err, 0);
    end

    // R5 temperature change during a frame is ignored
    run_frame(10'h2A5, 16, 1'b1, 0, got);
    check(got == exp_word(10'h2A5), "R5 mid-frame change", got, exp_word(10'h2A5));

    // R6 serial input held high gives the same frame
    run_frame(10'h1C3, 16, 1'b0, 1, got);
    check(got == exp_word(10'h1C3), "R6 sdi ignored", got, exp_word(10'h1C3));

    // R7 short frames
    run_frame(10'h155, 5, 1'b0, 0, got);
    check(err == 1'b1, "R7 err after 5 clocks", err, 1);
    tick(20);
    check(err == 1'b1, "R10 err holds while idle", err, 1);
    run_frame(10'h155, 16, 1'b0, 0, got);
    check(err == 1'b0, "R9 err after good frame", err, 0);
    run_frame(10'h0F0, 15, 1'b0, 0, got);
    check(err == 1'b1, "R7 err after 15 clocks", err, 1);

    // R9 empty pulse after an error
    run_frame(10'h0F0, 0, 1'b0, 0, got);
    check(err == 1'b0, "R9 err after empty pulse", err, 0);

    // R8 long frames
    run_frame(10'h201, 17, 1'b0, 0, got);
    check(err == 1'b1, "R8 err after 17 clocks", err, 1);
    run_frame(10'h3FE, 20, 1'b0, 0, got);
    check(err == 1'b1, "R8 err after 20 clocks", err, 1);
    check(got == exp_word(10'h3FE), "R4 long frame word", got, exp_word(10'h3FE));
    run_frame(10'h3FE, 1, 1'b0, 0, got);
    check(err == 1'b1, "R7 err after 1 clock", err, 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule